// File: doc/BRIEF.md
# Fractional Clock Divider with Dual-Modulus Period Selection

This block derives a slow clock from a fast input clock when the wanted ratio is not an integer. Each output period lasts either M or M+1 input cycles. A first-order numerator accumulator decides the length of every period, so the average ratio comes to M + L/D. The long periods are spread as evenly as integer timing allows.

The ratio is given by three inputs: the integer part M, the numerator L and the denominator D. They are captured on the first clock edge after reset, and again whenever `load_i` is high at a clock edge. A capture clears the accumulator and starts a fresh period on the next cycle. Between captures the inputs may change freely without effect. The output is high for the first input cycle of each period and low for the rest of it. Valid settings satisfy M >= 2 and L < D.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_ni` is low, `clk_o` is low. The first rising edge after release captures `int_i`, `num_i` and `den_i` and starts a period, so `clk_o` is high in the following cycle.
- R2: `clk_o` is high for exactly the first input cycle of each output period and low for every other cycle of that period.
- R3: Every output period lasts either M or M+1 input cycles.
- R4: In any D consecutive output periods, exactly L last M+1 cycles and D-L last M cycles.
- R5: Number the periods after a capture from j = 0. Period j lasts M+1 cycles exactly when floor((j+1)L/D) > floor(jL/D), and M cycles otherwise, so period 0 is always short. For M=2, L=7, D=13 the first 13 periods are 2,3,2,3,2,3,2,3,2,3,2,3,3.
- R6: In any window of k consecutive periods with k <= D, the count of long periods is floor(kL/D) or ceil(kL/D).
- R7: With L = 0, every period lasts exactly M cycles.
- R8: When `load_i` is high at a rising edge, the new ratio is captured, the current period is abandoned even if it is part-way through, and `clk_o` is high in the next cycle as period 0 of the new ratio begins.
- R9: Changes on `int_i`, `num_i` and `den_i` without `load_i` have no effect on the period sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock being divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture strobe for the ratio inputs; restarts the sequence |
| int_i | input | IntW | Integer part M of the ratio |
| num_i | input | FracW | Fraction numerator L |
| den_i | input | FracW | Fraction denominator D |
| clk_o | output | 1 | Divided clock, one input cycle high per period |

## Verification
The ratio table covers several cases, each aimed at a different fault. The main case is 2 + 7/13, which ends its cycle with two long periods back to back. L = 0 shows whether a long period leaks in when none should. L/D = 1/2 gives strict alternation, where the phase can be checked. L = D-1 produces almost every period long, 1/16 produces rare long periods, and two odd ratios move the carry to other points in the sequence. Each measured period is compared with the closed-form floor expression, which separates a wrong phase or a wrong carry threshold from a merely wrong average. Every window of up to D periods is checked for even spread, and directed runs cover reset capture, a mid-period reload, and input changes made without a strobe.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic {
    PER_SHORT = 1'b0,
    PER_LONG  = 1'b1
  } per_len_e;
endpackage

// File: rtl/fcd_cfg_reg.sv
module fcd_cfg_reg #(
  parameter int IntW  = 8,
  parameter int FracW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [IntW-1:0]  int_i,
  input  logic [FracW-1:0] num_i,
  input  logic [FracW-1:0] den_i,
  output logic [IntW-1:0]  int_o,
  output logic [FracW-1:0] num_o,
  output logic [FracW-1:0] den_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_o <= '0;
      num_o <= '0;
      den_o <= '0;
    end else if (take_i) begin
      int_o <= int_i;
      num_o <= num_i;
      den_o <= den_i;
    end
  end
endmodule

// File: rtl/fcd_accum.sv
module fcd_accum
  import fcd_pkg::*;
#(
  parameter int FracW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [FracW-1:0] start_num_i,
  input  logic             step_i,
  input  logic [FracW-1:0] num_i,
  input  logic [FracW-1:0] den_i,
  output per_len_e         sel_o,
  output logic [FracW-1:0] acc_o
);
  // sum can reach 2D-2, one extra bit
  localparam int SumW = FracW + 1;

  logic [FracW-1:0] acc_q;
  per_len_e         sel_q;
  logic [SumW-1:0]  sum;
  logic [SumW-1:0]  rem;
  logic             carry;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, num_i};
    carry = (sum >= {1'b0, den_i});
    rem   = carry ? (sum - {1'b0, den_i}) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      sel_q <= PER_SHORT;
    end else if (start_i) begin
      // cleared accumulator plus the first L, period 0 is short
      acc_q <= start_num_i;
      sel_q <= PER_SHORT;
    end else if (step_i) begin
      acc_q <= rem[FracW-1:0];
      sel_q <= carry ? PER_LONG : PER_SHORT;
    end
  end

  assign sel_o = sel_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/fcd_period_cnt.sv
module fcd_period_cnt
  import fcd_pkg::*;
#(
  parameter int IntW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [IntW-1:0] int_i,
  input  per_len_e        sel_i,
  output logic            end_o,
  output logic [IntW-1:0] cnt_o,
  output logic            pulse_o
);
  localparam int LenW = IntW + 1;

  logic [IntW-1:0] cnt_q;
  logic            pulse_q;
  logic [LenW-1:0] last_idx;
  logic            at_end;

  always_comb begin
    last_idx = {1'b0, int_i} + {{IntW{1'b0}}, sel_i == PER_LONG} - LenW'(1);
    at_end   = ({1'b0, cnt_q} == last_idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (start_i || at_end) begin
      cnt_q   <= '0;
      pulse_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_q + IntW'(1);
      pulse_q <= 1'b0;
    end
  end

  assign end_o   = at_end;
  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter int IntW  = 8,
  parameter int FracW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IntW-1:0]  int_i,
  input  logic [FracW-1:0] num_i,
  input  logic [FracW-1:0] den_i,
  output logic             clk_o
);
  logic             fresh_q;
  logic             take;
  logic             per_end;
  logic [IntW-1:0]  cfg_int;
  logic [FracW-1:0] cfg_num;
  logic [FracW-1:0] cfg_den;
  logic [FracW-1:0] acc_q;
  logic [IntW-1:0]  cnt_q;
  per_len_e         sel_q;

  // first edge after reset acts as a capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fresh_q <= 1'b1;
    else         fresh_q <= 1'b0;
  end

  assign take = load_i | fresh_q;

  fcd_cfg_reg #(.IntW(IntW), .FracW(FracW)) i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .int_i  (int_i),
    .num_i  (num_i),
    .den_i  (den_i),
    .int_o  (cfg_int),
    .num_o  (cfg_num),
    .den_o  (cfg_den)
  );

  fcd_accum #(.FracW(FracW)) i_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (take),
    .start_num_i (num_i),
    .step_i      (per_end),
    .num_i       (cfg_num),
    .den_i       (cfg_den),
    .sel_o       (sel_q),
    .acc_o       (acc_q)
  );

  fcd_period_cnt #(.IntW(IntW)) i_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (take),
    .int_i   (cfg_int),
    .sel_i   (sel_q),
    .end_o   (per_end),
    .cnt_o   (cnt_q),
    .pulse_o (clk_o)
  );
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk
  import fcd_pkg::*;
#(
  parameter int IntW  = 8,
  parameter int FracW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             fresh_i,
  input logic             clk_o_i,
  input logic [IntW-1:0]  cnt_i,
  input logic [IntW-1:0]  int_i,
  input logic [FracW-1:0] num_i,
  input logic [FracW-1:0] den_i,
  input logic [FracW-1:0] acc_i,
  input per_len_e         sel_i
);
  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_i |-> !clk_o_i);

  p_pulse_at_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_i |-> (clk_o_i == (cnt_i == '0)));

  p_len_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fresh_i |-> ({1'b0, cnt_i} <= {1'b0, int_i}));

  p_acc_below_den_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fresh_i && num_i < den_i) |-> (acc_i < den_i));

  p_no_long_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fresh_i && num_i == '0 && den_i != '0) |-> (sel_i == PER_SHORT));

  p_load_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (clk_o_i && cnt_i == '0 && sel_i == PER_SHORT));

  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !fresh_i) |=> ($stable(int_i) && $stable(num_i) && $stable(den_i)));
endmodule

bind frac_clk_div fcd_chk #(.IntW(IntW), .FracW(FracW)) i_fcd_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .fresh_i (fresh_q),
  .clk_o_i (clk_o),
  .cnt_i   (cnt_q),
  .int_i   (cfg_int),
  .num_i   (cfg_num),
  .den_i   (cfg_den),
  .acc_i   (acc_q),
  .sel_i   (sel_q)
);

// File: tb/test_frac_clk_div.sv
module test_frac_clk_div;
  localparam int NVEC = 7;
  // {M, L, D}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd2, 8'd7,  8'd13},
    {8'd3, 8'd0,  8'd5},
    {8'd4, 8'd1,  8'd2},
    {8'd2, 8'd1,  8'd3},
    {8'd5, 8'd3,  8'd8},
    {8'd2, 8'd12, 8'd13},
    {8'd3, 8'd1,  8'd16}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] int_i = '0;
  logic [7:0] num_i = '0;
  logic [7:0] den_i = '0;
  logic       clk_o;

  int n_checks = 0;
  int n_errors = 0;
  bit longs [0:63];

  always #5 clk_i = ~clk_i;

  frac_clk_div #(.IntW(8), .FracW(8)) i_frac_clk_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .int_i  (int_i),
    .num_i  (num_i),
    .den_i  (den_i),
    .clk_o  (clk_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_long(input int j, input int l, input int d);
    return (((j + 1) * l) / d) > ((j * l) / d);
  endfunction

  // Called at the negedge where clk_o is high; returns at the next start.
  task automatic measure(output int len);
    int c;
    c = 0;
    @(negedge clk_i);
    c++;
    chk(clk_o == 1'b0, "R2 second cycle low", int'(clk_o), 0);
    while (!clk_o && c < 400) begin
      @(negedge clk_i);
      c++;
    end
    len = c;
  endtask

  task automatic run_seq(input int m, input int l, input int d,
                         input int first, input int nper, input string tag);
    int len;
    int exp;
    for (int j = 0; j < nper; j++) begin
      measure(len);
      exp = m + int'(exp_long(first + j, l, d));
      chk(len == exp, $sformatf("R5 %s period %0d", tag, first + j), len, exp);
      chk(len == m || len == m + 1, "R3 length M or M+1", len, m);
      longs[first + j] = (len == m + 1);
    end
  endtask

  task automatic do_load(input int m, input int l, input int d);
    int_i  = 8'(m);
    num_i  = 8'(l);
    den_i  = 8'(d);
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
    chk(clk_o == 1'b1, "R8 start after load", int'(clk_o), 1);
  endtask

  initial begin
    #2_000_000;
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int m, l, d, cnt, lo, hi;
    bit bad;
    // R1: reset state and capture on first edge
    int_i = 8'd4; num_i = 8'd1; den_i = 8'd3;
    repeat (3) @(negedge clk_i);
    chk(clk_o == 1'b0, "R1 low in reset", int'(clk_o), 0);
    rst_ni = 1'b1;
    chk(clk_o == 1'b0, "R1 low at release", int'(clk_o), 0);
    @(negedge clk_i);
    chk(clk_o == 1'b1, "R1 start after reset", int'(clk_o), 1);
    run_seq(4, 1, 3, 0, 6, "after reset");

    // table of ratios
    for (int v = 0; v < NVEC; v++) begin
      m = int'(VEC[v][23:16]);
      l = int'(VEC[v][15:8]);
      d = int'(VEC[v][7:0]);
      do_load(m, l, d);
      run_seq(m, l, d, 0, 2 * d, $sformatf("%0d+%0d/%0d", m, l, d));
      // R4: each run of D periods holds L long ones
      for (int s = 0; s <= d; s += d) begin
        cnt = 0;
        for (int j = 0; j < d; j++) cnt += int'(longs[s + j]);
        chk(cnt == l, "R4 long count per D periods", cnt, l);
      end
      // R6: even spread over every window
      bad = 1'b0;
      cnt = 0; lo = 0;
      for (int s = 0; s < 2 * d; s++)
        for (int k = 1; k <= d && s + k <= 2 * d; k++) begin
          int c2;
          c2 = 0;
          for (int j = s; j < s + k; j++) c2 += int'(longs[j]);
          lo = (k * l) / d;
          hi = lo + int'((k * l) % d != 0);
          if (!bad && (c2 < lo || c2 > hi)) begin
            bad = 1'b1;
            cnt = c2;
          end
        end
      chk(!bad, $sformatf("R6 spread %0d+%0d/%0d", m, l, d), cnt, lo);
      if (l == 0) begin
        cnt = 0;
        for (int j = 0; j < 2 * d; j++) cnt += int'(longs[j]);
        chk(cnt == 0, "R7 no long period with L=0", cnt, 0);
      end
    end

    // R8: reload part-way through a long period
    do_load(4, 1, 2);
    run_seq(4, 1, 2, 0, 1, "pre reload");
    @(negedge clk_i);
    @(negedge clk_i);
    do_load(2, 0, 3);
    run_seq(2, 0, 3, 0, 3, "R8 after mid reload");

    // R9: inputs changed without load
    do_load(3, 1, 4);
    run_seq(3, 1, 4, 0, 4, "R9 before change");
    int_i = 8'd6; num_i = 8'd5; den_i = 8'd7;
    run_seq(3, 1, 4, 4, 8, "R9 inputs ignored");

    // R1: reset during operation
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(clk_o == 1'b0, "R1 low on async reset", int'(clk_o), 0);
    int_i = 8'd3; num_i = 8'd2; den_i = 8'd5;
    @(negedge clk_i);
    @(negedge clk_i);
    chk(clk_o == 1'b0, "R1 held low in reset", int'(clk_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(clk_o == 1'b1, "R1 restart after reset", int'(clk_o), 1);
    run_seq(3, 2, 5, 0, 10, "R1 after second reset");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule